// File: doc/BRIEF.md
# Rotating Capacitor Ratio Switch Controller

This block drives the switches of a ratioed switched-capacitor input stage. Each input branch holds a bank of unit capacitors. While a conversion runs, every capacitor in the active bank takes the feedback DAC charge in each clock period, but only a subset of them also samples the input. With a bank of N active capacitors and M of them on the input, the stage scales the input by M/N. A usual setting is N = 3 and M = 2, which gives a 2/3 scale. That scale is corrected later in the digital path, and it also leaves room for inputs above full scale.

The subset that samples the input moves by one position in every clock period. Over each run of N periods every capacitor therefore samples the input the same number of times, and capacitor mismatch turns into periodic noise at a known frequency instead of a gain error. If the conversion length is not a whole multiple of N, a small gain error is left over. A 2048-period conversion with N = 3 is an example of this.

A conversion begins with a one-cycle `conv_start`, which also loads the ratio inputs. The rotation index then starts at zero and steps modulo N until reset or the next start.

Top module: `rotcap_scaler`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `in_en`, `dac_en` and `rot_idx` to zero.
- R2: A clock edge that samples `conv_start` high with a legal ratio loads `ratio_num` and `ratio_den`. After that edge `rot_idx` is 0 and `in_en` has bits 0 to M-1 set. A ratio is legal when 1 <= M < N <= MAX_CAPS.
- R3: During a conversion, `rot_idx` goes up by one at each clock edge and returns from N-1 to 0.
- R4: During a conversion, `in_en` has exactly M bits set. These are the capacitors at positions `rot_idx`, `rot_idx`+1, ... up to M positions, counted modulo N.
- R5: During a conversion, `dac_en` has bits 0 to N-1 set, one bit for each capacitor of the active bank.
- R6: Bits N and above of both `in_en` and `dac_en` stay zero.
- R7: A start with an illegal ratio (N < 2, N > MAX_CAPS, M = 0 or M >= N) sends the block idle: all enables are 0 and `rot_idx` is 0 after that edge, and they stay so.
- R8: In any N consecutive periods of a conversion, each of the N capacitors samples the input exactly M times.
- R9: A start during a running conversion restarts the rotation at index 0 with the newly loaded ratio.
- R10: A capacitor never has its `in_en` bit set unless its `dac_en` bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; one period is one sampling period |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | One-cycle pulse that starts or restarts a conversion and loads the ratio |
| ratio_num | input | CW | M, the number of capacitors that sample the input |
| ratio_den | input | CW | N, the number of capacitors in the active bank |
| in_en | output | MAX_CAPS | Input-sampling enable, one bit per capacitor |
| dac_en | output | MAX_CAPS | DAC-sampling enable, one bit per capacitor |
| rot_idx | output | IW | Current rotation index, 0 to N-1 |

## Verification
Every output comes from a register. The value for a period is set at the same edge that samples `conv_start` or the previous state, so each result is due one edge after its cause and holds for the whole following period. The bench drives inputs on the falling edge. A behavioural model updates at each rising edge from the same inputs, and every output is compared against it at the next falling edge. The bench also checks the equal-share property by counting how many times each capacitor samples the input over whole rotation cycles, and it confirms that illegal ratios and restarts take effect exactly one edge after the start pulse.

// File: rtl/rotcap_pkg.sv
// Shared helpers for the rotating capacitor controller.
// Assumes ratio fields are small unsigned values (bank size up to a few tens).
package rotcap_pkg;

    // True when the requested ratio can be built from a bank of max_caps.
    function automatic logic ratio_legal(input int unsigned num,
                                         input int unsigned den,
                                         input int unsigned max_caps);
        return (num >= 1) && (num < den) && (den <= max_caps);
    endfunction

    // Cyclic distance from base to idx inside a ring of size den.
    function automatic int unsigned ring_offset(input int unsigned idx,
                                                input int unsigned base,
                                                input int unsigned den);
        return (idx >= base) ? (idx - base) : (idx + den - base);
    endfunction

endpackage

// File: rtl/rotcap_index.sv
// Rotation index counter. It clears on restart, steps modulo den while run is
// high and otherwise holds. rot_d is the value the next edge will load.
// Assumes den >= 2 whenever run is high.
module rotcap_index #(
    parameter int IW = 3,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic [CW-1:0] den,
    output logic [IW-1:0] rot_q,
    output logic [IW-1:0] rot_d
);
    logic [CW-1:0] rot_inc;

    // Next index: restart wins, otherwise wrap at den-1.
    always_comb begin
        rot_inc = CW'(rot_q) + CW'(1);
        if (restart)
            rot_d = '0;
        else if (run)
            rot_d = (rot_inc >= den) ? '0 : IW'(rot_inc);
        else
            rot_d = rot_q;
    end

    // Index register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rot_q <= '0;
        else        rot_q <= rot_d;
    end
endmodule

// File: rtl/rotcap_mask.sv
// Combinational enable pattern generator. For each capacitor slot it decides
// DAC membership (slot < den) and input membership (cyclic offset from base
// below num). Assumes base < den and num < den when enable is high.
module rotcap_mask #(
    parameter int MAX_CAPS = 8,
    parameter int IW       = 3,
    parameter int CW       = 4
) (
    input  logic                enable,
    input  logic [IW-1:0]       base,
    input  logic [CW-1:0]       num,
    input  logic [CW-1:0]       den,
    output logic [MAX_CAPS-1:0] in_mask,
    output logic [MAX_CAPS-1:0] dac_mask
);
    import rotcap_pkg::*;

    for (genvar g = 0; g < MAX_CAPS; g++) begin : g_slot
        logic in_bank;
        int unsigned off;

        // Per-slot membership decode.
        always_comb begin
            in_bank     = enable && (g < int'(den));
            off         = ring_offset(g, int'(base), int'(den));
            dac_mask[g] = in_bank;
            in_mask[g]  = in_bank && (off < int'(num));
        end
    end
endmodule

// File: rtl/rotcap_scaler.sv
// Top of the rotating capacitor ratio controller. A start pulse loads the
// ratio M/N. Enables are registered, so every pattern holds for a full clock
// period. The input window of M capacitors advances one slot per period.
// Assumes conv_start is synchronous to clk.
module rotcap_scaler #(
    parameter int MAX_CAPS = 8,
    localparam int IW = (MAX_CAPS > 1) ? $clog2(MAX_CAPS) : 1,
    localparam int CW = $clog2(MAX_CAPS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_start,
    input  logic [CW-1:0]       ratio_num,
    input  logic [CW-1:0]       ratio_den,
    output logic [MAX_CAPS-1:0] in_en,
    output logic [MAX_CAPS-1:0] dac_en,
    output logic [IW-1:0]       rot_idx
);
    import rotcap_pkg::*;

    logic                active_q;
    logic [CW-1:0]       num_q, den_q;
    logic                start_ok, run_next;
    logic [CW-1:0]       num_nx, den_nx;
    logic [IW-1:0]       rot_d;
    logic [MAX_CAPS-1:0] in_mask, dac_mask;
    logic [MAX_CAPS-1:0] in_en_q, dac_en_q;

    // Select the ratio that applies in the coming period.
    always_comb begin
        start_ok = conv_start && ratio_legal(int'(ratio_num), int'(ratio_den), MAX_CAPS);
        run_next = conv_start ? start_ok : active_q;
        num_nx   = conv_start ? ratio_num : num_q;
        den_nx   = conv_start ? ratio_den : den_q;
    end

    // Conversion state and latched ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            num_q    <= '0;
            den_q    <= '0;
        end else if (conv_start) begin
            active_q <= start_ok;
            num_q    <= ratio_num;
            den_q    <= ratio_den;
        end
    end

    rotcap_index #(.IW(IW), .CW(CW)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (conv_start),
        .run     (active_q),
        .den     (den_q),
        .rot_q   (rot_idx),
        .rot_d   (rot_d)
    );

    rotcap_mask #(.MAX_CAPS(MAX_CAPS), .IW(IW), .CW(CW)) u_mask (
        .enable   (run_next),
        .base     (rot_d),
        .num      (num_nx),
        .den      (den_nx),
        .in_mask  (in_mask),
        .dac_mask (dac_mask)
    );

    // Register the enables so they hold steady through the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_en_q  <= '0;
            dac_en_q <= '0;
        end else begin
            in_en_q  <= in_mask;
            dac_en_q <= dac_mask;
        end
    end

    assign in_en  = in_en_q;
    assign dac_en = dac_en_q;
endmodule

// File: rtl/rotcap_scaler_chk.sv
// Property checker for rotcap_scaler, attached by bind. It keeps its own copy
// of the loaded ratio, taken from the ports, aligned with the output registers.
module rotcap_scaler_chk #(
    parameter int MAX_CAPS = 8,
    parameter int IW = 3,
    parameter int CW = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                conv_start,
    input logic [CW-1:0]       ratio_num,
    input logic [CW-1:0]       ratio_den,
    input logic [MAX_CAPS-1:0] in_en,
    input logic [MAX_CAPS-1:0] dac_en,
    input logic [IW-1:0]       rot_idx
);
    logic          seen_q, act_q, good;
    logic [CW-1:0] m_q, n_q;
    logic [CW-1:0] rot_step;
    logic [IW-1:0] rot_exp;

    // Legal-ratio flag and expected successor of the index.
    always_comb begin
        good     = conv_start && (ratio_num >= 1) && (ratio_num < ratio_den)
                   && (int'(ratio_den) <= MAX_CAPS);
        rot_step = CW'(rot_idx) + CW'(1);
        rot_exp  = (rot_step == n_q) ? '0 : IW'(rot_step);
    end

    // Checker-side ratio tracking.
    always_ff @(posedge clk) begin
        seen_q <= 1'b1;
        if (!rst_n) begin
            act_q <= 1'b0;
            m_q   <= '0;
            n_q   <= '0;
        end else if (conv_start) begin
            act_q <= good;
            m_q   <= ratio_num;
            n_q   <= ratio_den;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        (seen_q && !$past(rst_n)) |-> (in_en == '0 && dac_en == '0 && rot_idx == '0));

    // R2
    start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good |=> (rot_idx == '0 && in_en[0]));

    // R3
    rot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !conv_start) |=> (rot_idx == $past(rot_exp)));

    // R4
    in_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> ($countones(in_en) == int'(m_q) && in_en[rot_idx]));

    // R5
    dac_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> ($countones(dac_en) == int'(n_q)
                   && ((dac_en & (dac_en + MAX_CAPS'(1))) == '0)));

    // R7
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> (in_en == '0 && dac_en == '0 && rot_idx == '0));

    // R10
    subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_en & ~dac_en) == '0));
endmodule

bind rotcap_scaler rotcap_scaler_chk #(.MAX_CAPS(MAX_CAPS), .IW(IW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .ratio_num  (ratio_num),
    .ratio_den  (ratio_den),
    .in_en      (in_en),
    .dac_en     (dac_en),
    .rot_idx    (rot_idx)
);

// File: tb/rotcap_scaler_bench.sv
// Bench for rotcap_scaler: behavioural reference compared on every clock,
// plus directed checks for reset, illegal ratios, restart and equal sharing.
module rotcap_scaler_bench;
    localparam int MAXC = 8;
    localparam int IW   = 3;
    localparam int CW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            conv_start = 1'b0;
    logic [CW-1:0]   ratio_num = '0;
    logic [CW-1:0]   ratio_den = '0;
    logic [MAXC-1:0] in_en, dac_en;
    logic [IW-1:0]   rot_idx;

    int checks = 0;
    int errors = 0;
    bit compare_on = 1'b0;

    int ref_act = 0, ref_m = 0, ref_n = 0, ref_rot = 0;

    always #2.5 clk = ~clk;

    rotcap_scaler #(.MAX_CAPS(MAXC)) u_rotcap_scaler (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
        .ratio_num(ratio_num), .ratio_den(ratio_den),
        .in_en(in_en), .dac_en(dac_en), .rot_idx(rot_idx)
    );

    function automatic logic [MAXC-1:0] exp_in(int act, int m, int n, int rot);
        logic [MAXC-1:0] v = '0;
        if (act != 0)
            for (int i = 0; i < n; i++)
                if (((i - rot + n) % n) < m) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [MAXC-1:0] exp_dac(int act, int n);
        logic [MAXC-1:0] v = '0;
        if (act != 0)
            for (int i = 0; i < n; i++) v[i] = 1'b1;
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: updates on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_act = 0; ref_m = 0; ref_n = 0; ref_rot = 0;
        end else if (conv_start) begin
            ref_m   = int'(ratio_num);
            ref_n   = int'(ratio_den);
            ref_act = (ref_m >= 1 && ref_m < ref_n && ref_n <= MAXC) ? 1 : 0;
            ref_rot = 0;
        end else if (ref_act != 0) begin
            ref_rot = (ref_rot + 1) % ref_n;
        end
    end

    // Per-cycle comparison on the falling edge.
    always @(negedge clk) begin
        if (compare_on) begin
            check("R3 rot_idx", 32'(rot_idx), 32'(ref_rot));
            check("R4 in_en", 32'(in_en), 32'(exp_in(ref_act, ref_m, ref_n, ref_rot)));
            check("R5 dac_en", 32'(dac_en), 32'(exp_dac(ref_act, ref_n)));
        end
    end

    task automatic start(int m, int n);
        @(negedge clk);
        ratio_num  = CW'(m);
        ratio_den  = CW'(n);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
    endtask

    // Count input samples per capacitor over whole rotation cycles (R8).
    task automatic share_test(int m, int n, int cycles);
        int cnt[MAXC];
        start(m, n);
        check("R2 origin rot", 32'(rot_idx), 0);
        check("R2 origin in_en", 32'(in_en), 32'((1 << m) - 1));
        for (int i = 0; i < MAXC; i++) cnt[i] = 0;
        for (int c = 0; c < cycles * n; c++) begin
            for (int i = 0; i < MAXC; i++) if (in_en[i]) cnt[i]++;
            @(negedge clk);
        end
        for (int i = 0; i < MAXC; i++)
            check((i < n) ? "R8 equal share" : "R6 upper slots idle",
                  32'(cnt[i]), 32'((i < n) ? cycles * m : 0));
    endtask

    initial begin : watchdog
        #100000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in_en", 32'(in_en), 0);
        check("R1 dac_en", 32'(dac_en), 0);
        check("R1 rot_idx", 32'(rot_idx), 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        repeat (2) @(negedge clk);

        share_test(2, 3, 6);
        share_test(1, 2, 5);
        share_test(3, 5, 4);
        share_test(7, 8, 3);
        share_test(1, 7, 3);

        // R9: restart mid-cycle with a new ratio.
        start(2, 3);
        @(negedge clk);
        start(3, 4);
        check("R9 restart rot", 32'(rot_idx), 0);
        check("R9 restart in_en", 32'(in_en), 32'h7);
        check("R9 restart dac_en", 32'(dac_en), 32'hF);
        @(negedge clk);
        check("R10 subset", 32'(in_en & ~dac_en), 0);

        // R7: illegal ratios put the block idle.
        start(3, 3);
        check("R7 m=n in_en", 32'(in_en), 0);
        check("R7 m=n dac_en", 32'(dac_en), 0);
        start(0, 4);
        check("R7 m=0 dac_en", 32'(dac_en), 0);
        start(2, 9);
        check("R7 n>max dac_en", 32'(dac_en), 0);
        repeat (4) @(negedge clk);
        check("R7 stays idle rot", 32'(rot_idx), 0);

        // R1: reset during a conversion.
        start(2, 3);
        repeat (2) @(negedge clk);
        compare_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset in_en", 32'(in_en), 0);
        check("R1 mid reset rot", 32'(rot_idx), 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        repeat (2) @(negedge clk);

        compare_on = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule